// File: doc/BRIEF.md
# Sensor Column Readout Sequencer

This block paces the readout of one image row from a column-addressed pixel array. A row start captures the window width and the readout mode. The block then raises the column sync line and holds it long enough to meet the pointer setup time. It presets the column pointer with one column clock while sync is held, and then issues one column clock per pixel. After the last pixel it issues the deselect clocks, and finally raises a one-cycle done flag.

The analog value of a pixel reaches the converter two column-clock periods after the clock that selects that pixel. To cover this delay, the converter clock runs for the window width plus two periods, each period aligned to a column-clock period. A valid flag marks the periods whose converter sample belongs to a pixel.

The mode sets two things. In full-row mode, sync is issued only after the sample-and-hold phase of the row has finished, and one deselect clock follows the pixels. In partial-row mode, sync is issued at once, before the sample-and-hold pulses. Pixel clocking waits until the sample-and-hold phase is reported finished, and two deselect clocks follow the pixels.

Top module: `colrd_seq`

## Requirements
- R1: While reset is high, and from reset until the next accepted row start, col_sync, col_clk, adc_clk, samp_valid and done are all low.
- R2: col_sync is high for exactly SETUP_CYC system cycles with col_clk low before col_clk rises. Exactly one col_clk rising edge per row occurs with col_sync high, and col_sync falls when that clock falls.
- R3: With partial = 1, col_sync rises in the cycle after the row start is sampled, before samp_done. With partial = 0, col_sync stays low until samp_done is sampled high. In both modes, no pixel clock is issued before samp_done has been seen.
- R4: After the sync clock, the number of col_clk rising edges equals win_width plus the deselect count, with col_sync low throughout.
- R5: The deselect count is 2 when partial = 1 and 1 when partial = 0. A win_width of 0 still produces the sync clock and the deselect clocks.
- R6: adc_clk has exactly win_width + 2 rising edges per row. Each of these edges coincides with the start of a column-clock period, and none occurs while col_sync is high.
- R7: samp_valid rises together with the third adc_clk rising edge of the row. It stays high for exactly win_width column-clock periods (2*HALF_PER system cycles each), so exactly win_width adc_clk rising edges occur with samp_valid high.
- R8: done is high for exactly one system cycle per row, after the last converter period. No clock output is high during that cycle.
- R9: A row start that arrives while a row is in progress is ignored. It neither changes the current row's counts nor starts another row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | One-cycle request to read a row; sampled only when idle |
| partial | input | 1 | 1 = partial-row window, 0 = full row; captured at row start |
| win_width | input | WIN_W | Number of pixels in the window; captured at row start |
| samp_done | input | 1 | Pulse marking the end of the row's sample-and-hold pulses |
| col_sync | output | 1 | Column pointer preset level (active high) |
| col_clk | output | 1 | Column shift clock |
| adc_clk | output | 1 | Converter clock, sampling on its rising edge |
| samp_valid | output | 1 | High while the current converter period carries a pixel |
| done | output | 1 | One-cycle pulse at the end of the row |

## Verification
The bench targets the mode-dependent deselect count. A design that used a single deselect clock in partial mode would leave the last column half selected, and this shows as one column edge too few. It also covers a window width of zero, where a design that skipped the deselect tail, or let the pixel counter wrap, would give no deselect clock or hundreds of edges. Valid alignment is checked by counting converter edges with and without the flag: an off-by-one in the two-period latency moves one edge from one count to the other. It further checks that sync is issued in the right order relative to samp_done in each mode, that a mid-row start request is ignored, and that a reset in mid-row leaves every output low.

// File: rtl/colrd_pkg.sv
package colrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SH,
        ST_SETUP,
        ST_SYNC_CLK,
        ST_HOLD,
        ST_RUN,
        ST_DONE
    } seq_st_e;

    // Column clocks needed after the last pixel to release the last column.
    function automatic logic [1:0] desel_count(input logic partial_mode);
        return partial_mode ? 2'd2 : 2'd1;
    endfunction

    // Column-clock periods of analog latency between selection and output.
    localparam int unsigned PIPE_LAT = 2;

endpackage

// File: rtl/colrd_phase.sv
module colrd_phase #(
    parameter int unsigned HALF_PER = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hi,
    output logic period_end
);
    localparam int unsigned PER = 2 * HALF_PER;
    localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;

    logic [PW-1:0] ph;

    assign hi         = (ph < PW'(HALF_PER));
    assign period_end = (ph == PW'(PER - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph <= '0;
        end else if (period_end) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end
endmodule

// File: rtl/colrd_ctrl.sv
module colrd_ctrl
    import colrd_pkg::*;
#(
    parameter int unsigned WIN_W     = 8,
    parameter int unsigned SETUP_CYC = 30,
    localparam int unsigned IW       = WIN_W + 2,
    localparam int unsigned SW       = $clog2(SETUP_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_start,
    input  logic             partial,
    input  logic [WIN_W-1:0] win_width,
    input  logic             samp_done,
    input  logic             period_end,
    output seq_st_e          st,
    output logic [IW-1:0]    idx,
    output logic [IW-1:0]    last_idx,
    output logic             lat_part
);
    logic [SW-1:0]    setup_cnt;
    logic [WIN_W-1:0] lat_w;
    logic             sh_seen;

    // Final converter period index: width + latency - 1.
    assign last_idx = {2'b00, lat_w} + IW'(PIPE_LAT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            setup_cnt <= '0;
            idx       <= '0;
            lat_w     <= '0;
            lat_part  <= 1'b0;
            sh_seen   <= 1'b0;
        end else begin
            if (st != ST_IDLE && samp_done) begin
                sh_seen <= 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (row_start) begin
                        lat_w     <= win_width;
                        lat_part  <= partial;
                        sh_seen   <= 1'b0;
                        setup_cnt <= '0;
                        st        <= partial ? ST_SETUP : ST_WAIT_SH;
                    end
                end
                ST_WAIT_SH: begin
                    if (samp_done) begin
                        setup_cnt <= '0;
                        st        <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (setup_cnt == SW'(SETUP_CYC - 1)) begin
                        st <= ST_SYNC_CLK;
                    end else begin
                        setup_cnt <= setup_cnt + 1'b1;
                    end
                end
                ST_SYNC_CLK: begin
                    if (period_end) begin
                        idx <= '0;
                        st  <= lat_part ? ST_HOLD : ST_RUN;
                    end
                end
                ST_HOLD: begin
                    if (sh_seen) begin
                        st <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (period_end) begin
                        if (idx == last_idx) begin
                            st <= ST_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/colrd_seq.sv
module colrd_seq
    import colrd_pkg::*;
#(
    parameter int unsigned WIN_W     = 8,
    parameter int unsigned HALF_PER  = 2,
    parameter int unsigned SETUP_CYC = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_start,
    input  logic             partial,
    input  logic [WIN_W-1:0] win_width,
    input  logic             samp_done,
    output logic             col_sync,
    output logic             col_clk,
    output logic             adc_clk,
    output logic             samp_valid,
    output logic             done
);
    localparam int unsigned IW = WIN_W + 2;

    seq_st_e       st;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic          lat_part;
    logic          ph_hi;
    logic          ph_end;
    logic          ph_run;
    logic [IW-1:0] col_limit;

    assign ph_run = (st == ST_SYNC_CLK) || (st == ST_RUN);

    colrd_phase #(.HALF_PER(HALF_PER)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .run        (ph_run),
        .hi         (ph_hi),
        .period_end (ph_end)
    );

    colrd_ctrl #(.WIN_W(WIN_W), .SETUP_CYC(SETUP_CYC)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .row_start  (row_start),
        .partial    (partial),
        .win_width  (win_width),
        .samp_done  (samp_done),
        .period_end (ph_end),
        .st         (st),
        .idx        (idx),
        .last_idx   (last_idx),
        .lat_part   (lat_part)
    );

    // Pixel periods plus deselect periods carry a column clock; the
    // remaining tail periods (latency flush) clock the converter only.
    assign col_limit = last_idx - IW'(PIPE_LAT - 1) + IW'(desel_count(lat_part));

    assign col_sync   = (st == ST_SETUP) || (st == ST_SYNC_CLK && ph_hi);
    assign col_clk    = ph_hi && ((st == ST_SYNC_CLK) ||
                                  (st == ST_RUN && idx < col_limit));
    assign adc_clk    = ph_hi && (st == ST_RUN);
    assign samp_valid = (st == ST_RUN) && (idx >= IW'(PIPE_LAT));
    assign done       = (st == ST_DONE);
endmodule

// File: rtl/colrd_chk.sv
module colrd_chk #(
    parameter int unsigned SETUP_CYC = 30
) (
    input logic clk,
    input logic rst,
    input logic col_sync,
    input logic col_clk,
    input logic adc_clk,
    input logic samp_valid,
    input logic done
);
    localparam int unsigned CW = $clog2(SETUP_CYC + 1);

    logic [CW-1:0] sync_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst || !col_sync) begin
            sync_lo_cnt <= '0;
        end else if (!col_clk && sync_lo_cnt < CW'(SETUP_CYC)) begin
            sync_lo_cnt <= sync_lo_cnt + 1'b1;
        end
    end

    // R2: sync held with the clock low for the full setup window
    a_r2_sync_setup: assert property (@(posedge clk) disable iff (rst)
        ($rose(col_clk) && col_sync) |-> (sync_lo_cnt == CW'(SETUP_CYC)));

    // R6: no converter clock while the pointer is being preset
    a_r6_no_adc_in_sync: assert property (@(posedge clk) disable iff (rst)
        col_sync |-> !adc_clk);

    // R6: every non-sync column edge is aligned to a converter edge
    a_r6_col_on_adc: assert property (@(posedge clk) disable iff (rst)
        ($rose(col_clk) && !col_sync) |-> $rose(adc_clk));

    // R7: valid window opens exactly on a converter edge
    a_r7_valid_aligned: assert property (@(posedge clk) disable iff (rst)
        $rose(samp_valid) |-> $rose(adc_clk));

    // R8: done lasts one cycle with all clocks quiet
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!col_clk && !adc_clk && !col_sync && !samp_valid));

    // R1: outputs low in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $fell(rst) |-> (!col_sync && !col_clk && !adc_clk && !samp_valid && !done));
endmodule

bind colrd_seq colrd_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .col_sync   (col_sync),
    .col_clk    (col_clk),
    .adc_clk    (adc_clk),
    .samp_valid (samp_valid),
    .done       (done)
);

// File: tb/sim_colrd_seq.sv
`timescale 1ns/1ps
module sim_colrd_seq;
    localparam int WIN_W     = 8;
    localparam int HALF_PER  = 2;
    localparam int SETUP_CYC = 30;
    localparam int WD_LIMIT  = 150000;
    localparam int NVEC      = 6;

    // {partial, width, expected column clock rises incl. sync clock}
    localparam logic [16:0] VECS [NVEC] = '{
        {1'b0, 8'd4, 8'd6},
        {1'b1, 8'd4, 8'd7},
        {1'b0, 8'd0, 8'd2},
        {1'b1, 8'd0, 8'd3},
        {1'b1, 8'd1, 8'd4},
        {1'b0, 8'd9, 8'd11}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_start = 1'b0;
    logic partial = 1'b0;
    logic [WIN_W-1:0] win_width = '0;
    logic samp_done = 1'b0;
    logic col_sync, col_clk, adc_clk, samp_valid, done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int m_col = 0, m_col_sync = 0, m_adc = 0, m_adc_val = 0;
    int m_val_cyc = 0, m_done = 0;
    logic p_col = 1'b0, p_adc = 1'b0;

    always #2.5 clk = ~clk;

    colrd_seq #(.WIN_W(WIN_W), .HALF_PER(HALF_PER), .SETUP_CYC(SETUP_CYC)) u0 (
        .clk(clk), .rst(rst), .row_start(row_start), .partial(partial),
        .win_width(win_width), .samp_done(samp_done), .col_sync(col_sync),
        .col_clk(col_clk), .adc_clk(adc_clk), .samp_valid(samp_valid), .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (col_clk && !p_col) begin
                m_col = m_col + 1;
                if (col_sync) m_col_sync = m_col_sync + 1;
            end
            if (adc_clk && !p_adc) begin
                m_adc = m_adc + 1;
                if (samp_valid) m_adc_val = m_adc_val + 1;
            end
            if (samp_valid) m_val_cyc = m_val_cyc + 1;
            if (done) m_done = m_done + 1;
        end
        p_col = col_clk;
        p_adc = adc_clk;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic p, input int w);
        @(negedge clk);
        row_start = 1'b1;
        partial   = p;
        win_width = WIN_W'(w);
        @(negedge clk);
        row_start = 1'b0;
    endtask

    task automatic pulse_sh();
        @(negedge clk);
        samp_done = 1'b1;
        @(negedge clk);
        samp_done = 1'b0;
    endtask

    task automatic wait_done(input int base_done);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (m_done > base_done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_row(input logic p, input int w, input int exp_col,
                           input bit extra_start);
        int b_col, b_sync, b_adc, b_aval, b_vc, b_done;
        int desel;
        desel  = p ? 2 : 1;
        b_col  = m_col;  b_sync = m_col_sync; b_adc = m_adc;
        b_aval = m_adc_val; b_vc = m_val_cyc; b_done = m_done;
        pulse_start(p, w);
        repeat (4) @(negedge clk);
        check("R3 sync order vs samp_done", int'(col_sync), int'(p));
        if (!p) begin
            repeat (40) @(negedge clk);
            check("R3 full row holds without samp_done", int'(col_sync || col_clk), 0);
        end
        pulse_sh();
        if (extra_start) begin
            repeat (10) @(negedge clk);
            pulse_start(~p, 9);
        end
        wait_done(b_done);
        check("R2 one column edge with sync", m_col_sync - b_sync, 1);
        check("R4/R5 column edges", m_col - b_col, exp_col);
        check("R5 deselect count", m_col - b_col - 1 - w, desel);
        check("R6 converter edges", m_adc - b_adc, w + 2);
        check("R7 converter edges with valid", m_adc_val - b_aval, w);
        check("R7 valid cycles", m_val_cyc - b_vc, w * 2 * HALF_PER);
        check("R8 one done pulse", m_done - b_done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sync", int'(col_sync), 0);
        check("R1 reset clocks", int'(col_clk || adc_clk), 0);
        check("R1 reset valid/done", int'(samp_valid || done), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", int'(col_sync || col_clk || adc_clk || done), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_row(VECS[v][16], int'(VECS[v][15:8]), int'(VECS[v][7:0]), 1'b0);
        end

        // R9: start request during a row is ignored
        run_row(1'b0, 3, 5, 1'b1);
        repeat (20) @(negedge clk);
        check("R9 no second row started", int'(col_sync || col_clk || adc_clk), 0);

        // R1: reset mid-row silences outputs
        pulse_start(1'b1, 6);
        pulse_sh();
        repeat (45) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 outputs low in reset", int'(col_sync || col_clk || adc_clk || samp_valid || done), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        check("R1 idle after mid-row reset", int'(col_sync || col_clk || adc_clk || done), 0);

        // R5: back-to-back row works after reset
        run_row(1'b1, 2, 5, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= WD_LIMIT);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule